// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns the full signed product of `2*WIDTH` bits. It takes one clock per multiplier bit, so each operation lasts `WIDTH` iterations.

In each iteration the block looks at the lowest multiplier bit together with the bit that was examined just before it. Where a run of ones starts, the multiplicand is subtracted from the high accumulator half. Where a run of ones ends, the multiplicand is added. For any other bit pair the accumulator is left unchanged. The high and low halves are then shifted right by one place as one arithmetic pair, and the multiplier register is rotated.

A caller raises `start_i` for one cycle while the block is idle and then waits for the single-cycle `done_o` pulse. The product stays on `product_o` until a later operation completes.

Top module: `booth_mult_seq`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, `busy_o` is 0, `done_o` is 0 and `product_o` is 0.
- R2: A `start_i` high at a rising edge while `busy_o` is 0 captures `x_i` and `y_i`. `busy_o` is then 1 for exactly `WIDTH` consecutive cycles.
- R3: `done_o` is 1 for exactly one cycle: the cycle right after the last busy cycle. `busy_o` is 0 in that cycle.
- R4: When `done_o` is 1, `product_o`, read as a signed value, equals the signed product of the captured `x_i` and `y_i` for general mixed-sign operands.
- R5: The product is exact when either operand or both operands equal -2^(WIDTH-1). For WIDTH=8, -128*-128 gives 16384 and -128*127 gives -16256.
- R6: A `start_i` pulse while `busy_o` is 1 is ignored. The running operation finishes on time with the product of its own operands.
- R7: `product_o` keeps its value while the block is idle, and changes only when an operation completes.
- R8: Zero and unit operands give exact products: 0*y = 0, -1*-1 = 1, and -128*1 = 1*-128 = -128 for WIDTH=8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| x_i | input | WIDTH | Multiplicand, two's complement |
| y_i | input | WIDTH | Multiplier, two's complement |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 2*WIDTH | Signed product, held until the next completion |

## Verification
A wrong add/subtract choice, or a shift that loses the sign, corrupts the accumulator. This shows up as a wrong `product_o` when `done_o` rises, which is `WIDTH` cycles after the start. The most negative operands are the sharpest test, because the accumulator sum needs one extra bit there. A wrong iteration count or a wrong handshake state shows up sooner, as a busy window that is not exactly `WIDTH` cycles long, or as a done pulse that is missing or too long. A start accepted while busy is caught by a product that belongs to the second operand pair.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    BOP_HOLD = 2'b00,
    BOP_ADD  = 2'b01,
    BOP_SUB  = 2'b10
  } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_i,
  input  logic      prev_i,
  output booth_op_e op_o
);
  always_comb begin
    unique case ({cur_i, prev_i})
      2'b10:   op_o = BOP_SUB;  // run of ones begins
      2'b01:   op_o = BOP_ADD;  // run of ones ends
      default: op_o = BOP_HOLD;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] operand_i,
  input  booth_op_e        op_i,
  output logic [WIDTH:0]   sum_o
);
  localparam int EXT_W = WIDTH + 1;

  logic [EXT_W-1:0] acc_ext, opd_ext;

  // one guard bit keeps the sign when the most negative operand is subtracted
  assign acc_ext = {acc_i[WIDTH-1], acc_i};
  assign opd_ext = {operand_i[WIDTH-1], operand_i};

  always_comb begin
    unique case (op_i)
      BOP_ADD: sum_o = acc_ext + opd_ext;
      BOP_SUB: sum_o = acc_ext - opd_ext;
      default: sum_o = acc_ext;
    endcase
  end
endmodule

// File: rtl/booth_shift.sv
module booth_shift #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0]   ext_i,
  input  logic [WIDTH-1:0] low_i,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  // arithmetic right shift of {ext, low}; the extended sign stays on top
  assign hi_o = ext_i[WIDTH:1];
  assign lo_o = {ext_i[0], low_i[WIDTH-1:1]};
endmodule

// File: rtl/booth_mult_seq.sv
module booth_mult_seq
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   x_i,
  input  logic [WIDTH-1:0]   y_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic [WIDTH-1:0]   x_q, y_q, u_q, v_q;
  logic               y_m1_q, busy_q, done_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [2*WIDTH-1:0] prod_q;

  booth_op_e        op;
  logic [WIDTH:0]   sum_ext;
  logic [WIDTH-1:0] u_nxt, v_nxt;

  booth_recode u_recode (
    .cur_i (y_q[0]),
    .prev_i(y_m1_q),
    .op_o  (op)
  );

  booth_addsub #(.WIDTH(WIDTH)) u_addsub (
    .acc_i    (u_q),
    .operand_i(x_q),
    .op_i     (op),
    .sum_o    (sum_ext)
  );

  booth_shift #(.WIDTH(WIDTH)) u_shift (
    .ext_i(sum_ext),
    .low_i(v_q),
    .hi_o (u_nxt),
    .lo_o (v_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q    <= '0;
      y_q    <= '0;
      u_q    <= '0;
      v_q    <= '0;
      y_m1_q <= 1'b0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      prod_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start_i) begin
        x_q    <= x_i;
        y_q    <= y_i;
        u_q    <= '0;
        v_q    <= '0;
        y_m1_q <= 1'b0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        u_q    <= u_nxt;
        v_q    <= v_nxt;
        y_q    <= {y_q[0], y_q[WIDTH-1:1]};
        y_m1_q <= y_q[0];
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          prod_q <= {u_nxt, v_nxt};
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign product_o = prod_q;

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && start_i) |=> busy_q);  // R2
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= LAST));  // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);  // R3
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!busy_q && $past(busy_q)));  // R3
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> ($stable(x_q) && $stable(y_m1_q) == $stable(y_m1_q)));  // R6
  AST_PROD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> $stable(prod_q));  // R7
endmodule

// File: tb/tb_booth_mult_seq.sv
module tb_booth_mult_seq;
  localparam int W = 8;
  localparam int NV = 12;
  localparam int TV_X [NV] = '{3, -3, 7, -12, 127, -128, 1, -128, -128, 0, -1, 85};
  localparam int TV_Y [NV] = '{5, 5, -9, -11, 127, 1, -128, -128, 127, -77, -1, -86};
  localparam int TV_P [NV] = '{15, -15, -63, 132, 16129, -128, -128, 16384, -16256, 0, 1, -7310};

  logic clk = 0, rst_n = 0, start = 0;
  logic [W-1:0] x = '0, y = '0;
  logic busy, done;
  logic [2*W-1:0] prod;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  booth_mult_seq #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .x_i(x), .y_i(y),
    .busy_o(busy), .done_o(done), .product_o(prod)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // runs one op; optional stray start while busy (R6)
  task automatic run_op(input int ox, input int oy, input int exp, input string req,
                        input bit stray);
    int busy_cycles;
    @(negedge clk);
    x = ox[W-1:0]; y = oy[W-1:0]; start = 1;
    @(negedge clk);
    start = 0;
    check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
    busy_cycles = 1;
    if (stray) begin
      x = 8'h55; y = 8'h33; start = 1;
      @(negedge clk);
      start = 0;
      if (busy) busy_cycles++;
    end
    while (busy === 1'b1 && busy_cycles < 4 * W) begin
      @(negedge clk);
      if (busy) busy_cycles++;
    end
    check(busy_cycles == W, "R2 busy length", busy_cycles, W);
    check(done === 1'b1, "R3 done after busy", int'(done), 1);
    check($signed(prod) == exp, req, int'($signed(prod)), exp);
    check(exp == ox * oy, {req, " table"}, exp, ox * oy);
    @(negedge clk);
    check(done === 1'b0, "R3 done one cycle", int'(done), 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int held;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && prod === '0, "R1 in reset", int'(prod), 0);
    rst_n = 1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && prod === '0, "R1 after reset", int'(prod), 0);

    // R4 R5 R8 table
    for (int i = 0; i < NV; i++) begin
      string tag;
      if (TV_X[i] == -128 || TV_Y[i] == -128) tag = "R5 most negative";
      else if (TV_X[i] == 0 || TV_X[i] == 1 || TV_X[i] == -1) tag = "R8 zero/unit";
      else tag = "R4 product";
      run_op(TV_X[i], TV_Y[i], TV_P[i], tag, 1'b0);
    end

    // R7 hold while idle, start low, inputs moving
    held = int'($signed(prod));
    x = 8'h7f; y = 8'h80;
    repeat (6) @(negedge clk);
    check($signed(prod) == held, "R7 idle hold", int'($signed(prod)), held);

    // R6 stray start during busy
    run_op(-77, 93, -7161, "R6 stray start ignored", 1'b1);
    @(negedge clk);
    check(busy === 1'b0, "R6 no second op", int'(busy), 0);

    // R5 again after stray, R8 unit by zero
    run_op(-128, -1, 128, "R5 min times minus one", 1'b0);
    run_op(1, 0, 0, "R8 one times zero", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule